// File: doc/BRIEF.md
# Mapping-Register Port With Mirrored Window Decode

This block sits between an 8-bit CPU with a 24-bit address bus and a table of sixteen 12-bit mapping registers. It recognises accesses to a small register window and turns a qualified CPU write into a one-cycle table write strobe. The strobe carries a 4-bit register index and a 12-bit word. The low byte of the word comes from the CPU data bus. The upper nibble comes from a 4-bit side port, which software loads before it performs the write. A CPU read of the window returns the low byte of the indexed entry.

The address compare does not look at address bit 16. The window therefore answers at `0x000900` and also at `0x010900`. When bank 0 has been remapped, software can still reach the registers through bank 1. Every access to the window copies the side nibble into a readback latch. While a separate enable bit is set, that latch drives the side lines, so software can read the upper nibble back through the side port. A further side-port bit controls map mode. When that bit is not driven, a pull-up holds map mode off.

Top module: `mapreg_port`

## Requirements
- R1: `win_sel` is 1 exactly when address bits 23..17 are 0, bits 15..12 are 0, bits 10, 9 and 7 are 0, and bits 11 and 8 are 1. Bits 6..0 are don't-care.
- R2: Address bit 16 has no effect on `win_sel`, so every window address in bank 0 is also selected with bit 16 set.
- R3: A cycle with `win_sel`, `cpu_we` and `cpu_phi2` all 1 makes `tbl_we` 1 in the following cycle. In that cycle `tbl_idx` equals the address bits 3..0 of the access, and `tbl_wdata` equals {`sp_nibble`, `cpu_wdata`} as they were during the access.
- R4: `tbl_we` is 0 after any cycle in which the window is not selected, the access is a read, or `cpu_phi2` is 0. `tbl_idx` and `tbl_wdata` then keep their values.
- R5: `sp_nibble` takes its value from one of three sources, in this order of priority: `sp_data_val` when `sp_data_oe` is 1; otherwise the readback latch when `sp_rb_drive` is 1; otherwise 4'hF from the pull-ups.
- R6: In every cycle with `win_sel` 1 (read or write), the readback latch (`sp_rb_data`) loads `sp_nibble` for the next cycle. In all other cycles it holds its value.
- R7: `sp_rb_drive` equals `sp_rb_en` except during a window write (`win_sel` and `cpu_we`), when it is 0.
- R8: `tbl_ridx` follows address bits 3..0. `cpu_rdata` equals `tbl_rdata` during a window read and is 0 at all other times.
- R9: `map_en` becomes 1 in the cycle after one in which `sp_mm_oe` is 1 and `sp_mm_val` is 0 (the line is pulled low). In every other case it becomes 0.
- R10: While `rst_n` is 0, `tbl_we`, `map_en`, `tbl_idx`, `tbl_wdata` and `sp_rb_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write access |
| cpu_phi2 | input | 1 | High phase of the CPU clock, qualifies writes |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| win_sel | output | 1 | Register window selected |
| sp_data_val | input | 4 | Side-port output value for the upper nibble |
| sp_data_oe | input | 1 | Side port drives the nibble lines |
| sp_rb_en | input | 1 | Side-port bit that enables the readback latch |
| sp_mm_val | input | 1 | Side-port map-mode bit value (low = map on) |
| sp_mm_oe | input | 1 | Side port drives the map-mode line |
| sp_nibble | output | 4 | Resolved nibble line value |
| sp_rb_drive | output | 1 | Readback latch is driving the nibble lines |
| sp_rb_data | output | 4 | Readback latch content |
| map_en | output | 1 | Map mode active |
| tbl_we | output | 1 | Table write strobe |
| tbl_idx | output | 4 | Table write index |
| tbl_wdata | output | 12 | Table write word |
| tbl_ridx | output | 4 | Table read index |
| tbl_rdata | input | 8 | Low byte of the indexed table entry |

## Verification
The bench uses near-miss addresses that differ from a window address in exactly one compared bit. A decoder that mis-wires one bit then matches such an address, or misses a real one. It also presents each window address with bit 16 set and with it clear. A decoder that still compares bit 16 loses the bank-1 mirror. Write cycles with `cpu_phi2` low and window reads check that no strobe is issued; a design without the phase qualifier writes the table twice. Cycles in which the readback enable is set during a window write show whether the latch is held off the lines; if it were not, a stale nibble would end up in the written word.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned LO_W   = 8;
    localparam int unsigned HI_W   = 4;
    localparam int unsigned IDX_W  = 4;
    // Compared bits: 23..17 and 15..7; bit 16 left out so bank 1 mirrors bank 0
    localparam logic [ADDR_W-1:0] WIN_CARE  = 24'hFE_FF80;
    localparam logic [ADDR_W-1:0] WIN_MATCH = 24'h00_0900;
endpackage

// File: rtl/mrp_decode.sv
module mrp_decode #(
    parameter int unsigned           ADDR_W = mrp_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0]     CARE   = mrp_pkg::WIN_CARE,
    parameter logic [ADDR_W-1:0]     MATCH  = mrp_pkg::WIN_MATCH
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (CARE[i]) begin : g_cmp
            assign bit_ok[i] = (addr[i] == MATCH[i]);
        end else begin : g_skip
            assign bit_ok[i] = 1'b1;
        end
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/mrp_side_mux.sv
module mrp_side_mux #(
    parameter int unsigned HI_W = mrp_pkg::HI_W
) (
    input  logic [HI_W-1:0] port_val,
    input  logic            port_oe,
    input  logic            rb_en,
    input  logic            win_write,
    input  logic [HI_W-1:0] latch_val,
    output logic            rb_drive,
    output logic [HI_W-1:0] nibble
);
    assign rb_drive = rb_en & ~win_write;

    for (genvar i = 0; i < HI_W; i++) begin : g_line
        always_comb begin
            if (port_oe)       nibble[i] = port_val[i];
            else if (rb_drive) nibble[i] = latch_val[i];
            else               nibble[i] = 1'b1;
        end
    end
endmodule

// File: rtl/mapreg_port.sv
module mapreg_port #(
    parameter int unsigned ADDR_W = mrp_pkg::ADDR_W,
    parameter int unsigned LO_W   = mrp_pkg::LO_W,
    parameter int unsigned HI_W   = mrp_pkg::HI_W,
    parameter int unsigned IDX_W  = mrp_pkg::IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [LO_W-1:0]      cpu_wdata,
    input  logic                 cpu_we,
    input  logic                 cpu_phi2,
    output logic [LO_W-1:0]      cpu_rdata,
    output logic                 win_sel,
    input  logic [HI_W-1:0]      sp_data_val,
    input  logic                 sp_data_oe,
    input  logic                 sp_rb_en,
    input  logic                 sp_mm_val,
    input  logic                 sp_mm_oe,
    output logic [HI_W-1:0]      sp_nibble,
    output logic                 sp_rb_drive,
    output logic [HI_W-1:0]      sp_rb_data,
    output logic                 map_en,
    output logic                 tbl_we,
    output logic [IDX_W-1:0]     tbl_idx,
    output logic [LO_W+HI_W-1:0] tbl_wdata,
    output logic [IDX_W-1:0]     tbl_ridx,
    input  logic [LO_W-1:0]      tbl_rdata
);
    localparam int unsigned WORD_W = LO_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0]   latch;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] wd;
        logic              map;
    } state_t;

    state_t state_d, state_q;
    logic   win_write;
    logic   win_read;

    mrp_decode #(
        .ADDR_W (ADDR_W),
        .CARE   (mrp_pkg::WIN_CARE),
        .MATCH  (mrp_pkg::WIN_MATCH)
    ) u_decode (
        .addr (cpu_addr),
        .hit  (win_sel)
    );

    assign win_write = win_sel & cpu_we;
    assign win_read  = win_sel & ~cpu_we;

    mrp_side_mux #(
        .HI_W (HI_W)
    ) u_side (
        .port_val  (sp_data_val),
        .port_oe   (sp_data_oe),
        .rb_en     (sp_rb_en),
        .win_write (win_write),
        .latch_val (state_q.latch),
        .rb_drive  (sp_rb_drive),
        .nibble    (sp_nibble)
    );

    always_comb begin
        state_d     = state_q;
        state_d.we  = win_write & cpu_phi2;
        state_d.map = sp_mm_oe & ~sp_mm_val;
        if (win_sel) begin
            state_d.latch = sp_nibble;
        end
        if (win_write && cpu_phi2) begin
            state_d.idx = cpu_addr[IDX_W-1:0];
            state_d.wd  = {sp_nibble, cpu_wdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_rdata  = win_read ? tbl_rdata : '0;
    assign tbl_ridx   = cpu_addr[IDX_W-1:0];
    assign sp_rb_data = state_q.latch;
    assign map_en     = state_q.map;
    assign tbl_we     = state_q.we;
    assign tbl_idx    = state_q.idx;
    assign tbl_wdata  = state_q.wd;
endmodule

// File: rtl/mapreg_port_chk.sv
module mapreg_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic        cpu_phi2,
    input logic [7:0]  cpu_rdata,
    input logic        win_sel,
    input logic        sp_mm_val,
    input logic        sp_mm_oe,
    input logic [3:0]  sp_nibble,
    input logic        sp_rb_drive,
    input logic [3:0]  sp_rb_data,
    input logic        map_en,
    input logic        tbl_we,
    input logic [3:0]  tbl_idx,
    input logic [11:0] tbl_wdata
);
    p_sel_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> (cpu_addr[23:17] == 7'd0));

    p_strobe_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(win_sel && cpu_we && cpu_phi2));

    p_strobe_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (tbl_idx == $past(cpu_addr[3:0]) &&
                    tbl_wdata == {$past(sp_nibble), $past(cpu_wdata)}));

    p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_sel && cpu_we && cpu_phi2) |=> !tbl_we);

    p_latch_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |=> (sp_rb_data == $past(sp_nibble)));

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_sel |=> $stable(sp_rb_data));

    p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && cpu_we) |-> !sp_rb_drive);

    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_sel && !cpu_we) |-> (cpu_rdata == 8'h00));

    p_map_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_mm_oe && !sp_mm_val) |=> map_en);

    p_map_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sp_mm_oe && !sp_mm_val) |=> !map_en);
endmodule

bind mapreg_port mapreg_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_we      (cpu_we),
    .cpu_phi2    (cpu_phi2),
    .cpu_rdata   (cpu_rdata),
    .win_sel     (win_sel),
    .sp_mm_val   (sp_mm_val),
    .sp_mm_oe    (sp_mm_oe),
    .sp_nibble   (sp_nibble),
    .sp_rb_drive (sp_rb_drive),
    .sp_rb_data  (sp_rb_data),
    .map_en      (map_en),
    .tbl_we      (tbl_we),
    .tbl_idx     (tbl_idx),
    .tbl_wdata   (tbl_wdata)
);

// File: tb/mapreg_port_bench.sv
`timescale 1ns/1ps
module mapreg_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_phi2 = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        win_sel;
    logic [3:0]  sp_data_val = '0;
    logic        sp_data_oe = 1'b0;
    logic        sp_rb_en = 1'b0;
    logic        sp_mm_val = 1'b0;
    logic        sp_mm_oe = 1'b0;
    logic [3:0]  sp_nibble;
    logic        sp_rb_drive;
    logic [3:0]  sp_rb_data;
    logic        map_en;
    logic        tbl_we;
    logic [3:0]  tbl_idx;
    logic [11:0] tbl_wdata;
    logic [3:0]  tbl_ridx;
    logic [7:0]  tbl_rdata = '0;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // bench model state (values after the most recent rising edge)
    logic [3:0]  m_latch = '0;
    logic        m_we = 1'b0;
    logic [3:0]  m_idx = '0;
    logic [11:0] m_wd = '0;
    logic        m_map = 1'b0;

    always #2 clk = ~clk;

    mapreg_port u_mapreg_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_phi2(cpu_phi2), .cpu_rdata(cpu_rdata), .win_sel(win_sel),
        .sp_data_val(sp_data_val), .sp_data_oe(sp_data_oe), .sp_rb_en(sp_rb_en),
        .sp_mm_val(sp_mm_val), .sp_mm_oe(sp_mm_oe), .sp_nibble(sp_nibble),
        .sp_rb_drive(sp_rb_drive), .sp_rb_data(sp_rb_data), .map_en(map_en),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata)
    );

    function automatic bit exp_sel(input logic [23:0] a);
        return (a[23:17] == 7'd0) && (a[15:12] == 4'd0) && a[11] && !a[10] &&
               !a[9] && a[8] && !a[7];
    endfunction

    function automatic logic exp_drive();
        return sp_rb_en && !(exp_sel(cpu_addr) && cpu_we);
    endfunction

    function automatic logic [3:0] exp_nib();
        if (sp_data_oe) return sp_data_val;
        if (exp_drive()) return m_latch;
        return 4'hF;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit s;
        s = exp_sel(cpu_addr);
        check(win_sel == s, cpu_addr[16] ? "R2 mirrored select" : "R1 select",
              32'(win_sel), 32'(s));
        check(sp_rb_drive == exp_drive(), "R7 readback drive", 32'(sp_rb_drive), 32'(exp_drive()));
        check(sp_nibble == exp_nib(), "R5 nibble source", 32'(sp_nibble), 32'(exp_nib()));
        check(sp_rb_data == m_latch, "R6 readback latch", 32'(sp_rb_data), 32'(m_latch));
        check(cpu_rdata == ((s && !cpu_we) ? tbl_rdata : 8'h00), "R8 read data",
              32'(cpu_rdata), 32'((s && !cpu_we) ? tbl_rdata : 8'h00));
        check(tbl_ridx == cpu_addr[3:0], "R8 read index", 32'(tbl_ridx), 32'(cpu_addr[3:0]));
        check(map_en == m_map, "R9 map mode", 32'(map_en), 32'(m_map));
        check(tbl_we == m_we, m_we ? "R3 strobe" : "R4 no strobe", 32'(tbl_we), 32'(m_we));
        check(tbl_idx == m_idx, m_we ? "R3 index" : "R4 index hold", 32'(tbl_idx), 32'(m_idx));
        check(tbl_wdata == m_wd, m_we ? "R3 word" : "R4 word hold", 32'(tbl_wdata), 32'(m_wd));
    endtask

    // advance the model by the edge that will consume the current inputs
    task automatic model_edge();
        bit s;
        logic [3:0] n;
        s = exp_sel(cpu_addr);
        n = exp_nib();
        m_map = sp_mm_oe && !sp_mm_val;
        m_we  = s && cpu_we && cpu_phi2;
        if (m_we) begin
            m_idx = cpu_addr[3:0];
            m_wd  = {n, cpu_wdata};
        end
        if (s) m_latch = n;
    endtask

    task automatic step(input logic [23:0] a, input bit we, input bit phi,
                        input logic [7:0] wd, input bit doe, input logic [3:0] dval,
                        input bit rb, input bit mmoe, input bit mmval,
                        input logic [7:0] rd);
        @(negedge clk);
        check_all();
        cpu_addr = a; cpu_we = we; cpu_phi2 = phi; cpu_wdata = wd;
        sp_data_oe = doe; sp_data_val = dval; sp_rb_en = rb;
        sp_mm_oe = mmoe; sp_mm_val = mmval; tbl_rdata = rd;
        #0.1;
        model_edge();
    endtask

    function automatic logic [23:0] rand_addr();
        int unsigned k;
        logic [23:0] a;
        k = $urandom_range(0, 3);
        a = {7'd0, 1'($urandom_range(0, 1)), 4'd0, 4'b1001, 1'b0, 7'($urandom)};
        if (k == 2) begin
            // near miss: flip one compared bit (never bit 16 or bits 6..0)
            int unsigned b;
            b = $urandom_range(7, 23);
            if (b == 16) b = 17;
            a[b] = ~a[b];
        end else if (k == 3) begin
            a = 24'($urandom);
        end
        return a;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state with active-looking inputs
        cpu_addr = 24'h000905; cpu_we = 1'b1; cpu_phi2 = 1'b1; cpu_wdata = 8'hA5;
        sp_data_oe = 1'b1; sp_data_val = 4'h7; sp_mm_oe = 1'b1; sp_mm_val = 1'b0;
        repeat (3) @(negedge clk);
        check(tbl_we == 1'b0, "R10 reset strobe", 32'(tbl_we), 32'd0);
        check(map_en == 1'b0, "R10 reset map", 32'(map_en), 32'd0);
        check(sp_rb_data == 4'h0, "R10 reset latch", 32'(sp_rb_data), 32'd0);
        check(tbl_wdata == 12'h000, "R10 reset word", 32'(tbl_wdata), 32'd0);
        check(tbl_idx == 4'h0, "R10 reset index", 32'(tbl_idx), 32'd0);
        cpu_addr = '0; cpu_we = 1'b0; cpu_phi2 = 1'b0; sp_data_oe = 1'b0; sp_mm_oe = 1'b0;
        rst_n = 1'b1;

        // directed corners
        step(24'h000905, 1, 1, 8'h3C, 1, 4'hA, 0, 1, 0, 8'h00); // R3 bank 0 write
        step(24'h010907, 1, 1, 8'hC3, 1, 4'h5, 0, 1, 0, 8'h00); // R2 bank 1 write
        step(24'h000907, 0, 1, 8'h00, 0, 4'h0, 1, 0, 0, 8'h9E); // R6 readback read
        step(24'h000903, 1, 0, 8'h11, 1, 4'h2, 0, 0, 1, 8'h00); // R4 phase low
        step(24'h000903, 1, 1, 8'h22, 0, 4'h0, 1, 0, 0, 8'h00); // R7 write, rb held off -> pull-ups
        step(24'h000983, 1, 1, 8'h44, 1, 4'h1, 0, 0, 0, 8'h00); // R1 bit 7 near miss
        step(24'h020905, 1, 1, 8'h55, 1, 4'h1, 0, 0, 0, 8'h00); // R1 bit 17 near miss
        step(24'h00097F, 0, 0, 8'h00, 0, 4'h0, 0, 0, 0, 8'h6B); // R8 read, don't-care low bits
        step(24'h000000, 0, 0, 8'h00, 0, 4'h0, 1, 0, 0, 8'h00); // R5 latch drives lines

        for (int i = 0; i < 4000; i++) begin
            step(rand_addr(), 1'($urandom), 1'($urandom_range(0, 3) != 0), 8'($urandom),
                 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 8'($urandom));
        end
        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule